// File: doc/BRIEF.md
# Four-Operand Signed-Digit Radix-4 Adder

This block sums four signed-digit radix-4 numbers of `N` digits each. Every digit takes a value from -3 to +3. The result has `N+1` digits in the same number system. The addition time does not depend on `N`, because no carry ripples across more than one position. Each column first adds its four digits into a column sum in -12..+12. That sum is split into a carry worth four and a remainder. The split is chosen from the sign of the column sum one position lower. Each final digit is then the remainder of its own column plus the carry from the column below. Since that carry and that remainder can never share a sign, the final digit always fits in -3..+3.

The adder is a combinational core behind a valid/ready stream interface with one output register. An operand set is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its sum appears on `out_sum`, with `out_valid` high, after that same edge. The sum stays there until a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled consumer therefore holds off new operands with no loss.

Top module: `sdr4_quad_add`

## Requirements
- R1: Each digit is a 3-bit code. Bit 2 is the sign (1 = negative) and bits 1:0 are the magnitude. On input, the code 3'b100 counts as zero and gives the same sum as 3'b000.
- R2: The value of `out_sum`, with digit i weighted by 4^i, equals the sum of the values of `in_x`, `in_y`, `in_u` and `in_v` for the accepted operand set.
- R3: Every output digit lies in -3..+3, and a zero output digit is always encoded as 3'b000, never 3'b100.
- R4: Let DS_i be the column sum at position i. If DS_{i-1} > 0, the carry is ceil(DS_i/4) and the remainder lies in -3..0. Otherwise the carry is floor(DS_i/4) and the remainder lies in 0..3. "Otherwise" includes DS_{i-1} = 0 and position 0.
- R5: Output digit i equals the remainder of column i plus the carry of column i-1, and the top digit N equals the carry of column N-1. As a result, changing only the top input column leaves output digits 0..N-2 unchanged.
- R6: Take, most significant digit first, the operands (3,-2,-1,1), (0,-3,0,2), (1,2,-1,0) and (1,0,-3,0). With N = 4 they give the output (1,0,0,-1,3).
- R7: An operand set is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold their values across the clock edge.
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_x | input | 3*N | First operand, digit i in bits [3i+2:3i] |
| in_y | input | 3*N | Second operand |
| in_u | input | 3*N | Third operand |
| in_v | input | 3*N | Fourth operand |
| out_valid | output | 1 | Sum register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 3*(N+1) | Signed-digit sum, digit i in bits [3i+2:3i] |

## Verification
A sum is due on `out_sum` one rising edge after its operands are accepted. It stays there for every further edge on which the consumer does not take it. The bench drives inputs and samples outputs at the falling edge. A queue holds the expected results, which are built digit by digit from the carry-choice rule by searching for the one remainder in the allowed band. Each cycle the bench checks `out_valid` against whether the queue holds an entry, and compares `out_sum` with the queue's head. An entry is pushed or popped only when the matching handshake is seen just before the next rising edge. Stalls and back-to-back transfers therefore line up with the one-cycle latency.

// File: rtl/sdr4_pkg.sv
package sdr4_pkg;

  // Width of a column sum of four digits (-12..+12)
  localparam int SUM_W = 5;

  typedef logic [2:0] sd_code_t;

  // Sign-magnitude code to two's complement value; 3'b100 yields zero
  function automatic logic signed [2:0] sd_decode(input sd_code_t c);
    logic signed [2:0] m;
    m = $signed({1'b0, c[1:0]});
    return c[2] ? -m : m;
  endfunction

  // Two's complement value (-3..+3) to sign-magnitude code
  function automatic sd_code_t sd_encode(input logic signed [2:0] v);
    logic [1:0] mag;
    mag = v[2] ? (~v[1:0] + 2'd1) : v[1:0];
    return {v[2], mag};
  endfunction

endpackage

// File: rtl/sdr4_col_split.sv
module sdr4_col_split
  import sdr4_pkg::*;
(
  input  logic signed [SUM_W-1:0] col_sum,
  input  logic                    below_pos,
  output logic signed [2:0]       carry,
  output logic signed [2:0]       part
);

  logic signed [2:0] fl_q;
  logic [1:0]        rem;
  logic              bump;

  // Upper bits give floor(col_sum/4); lower bits give the non-negative remainder
  assign fl_q = col_sum[SUM_W-1:2];
  assign rem  = col_sum[1:0];

  // A positive lower column may send a positive carry: keep the remainder non-positive
  assign bump = below_pos && (rem != 2'b00);

  always_comb begin
    if (bump) begin
      carry = fl_q + 3'sd1;
      part  = {1'b1, rem};
    end else begin
      carry = fl_q;
      part  = {1'b0, rem};
    end
  end

endmodule

// File: rtl/sdr4_digit_merge.sv
module sdr4_digit_merge
  import sdr4_pkg::*;
(
  input  logic signed [2:0] part,
  input  logic signed [2:0] carry_in,
  output sd_code_t          digit
);

  logic signed [2:0] total;

  // Operands never share a sign, so the result stays within -3..+3
  assign total = part + carry_in;
  assign digit = sd_encode(total);

endmodule

// File: rtl/sdr4_sum_core.sv
module sdr4_sum_core
  import sdr4_pkg::*;
#(
  parameter int N = 4,
  localparam int XW = 3 * N,
  localparam int ZW = 3 * (N + 1)
) (
  input  logic [XW-1:0] op_x,
  input  logic [XW-1:0] op_y,
  input  logic [XW-1:0] op_u,
  input  logic [XW-1:0] op_v,
  output logic [ZW-1:0] sum
);

  logic signed [SUM_W-1:0] col_sum [N];
  logic                    below_pos [N];
  logic signed [2:0]       col_carry [N];
  logic signed [2:0]       col_part  [N];

  for (genvar i = 0; i < N; i++) begin : g_col
    logic signed [2:0] dx, dy, du, dv;
    assign dx = sd_decode(op_x[3*i +: 3]);
    assign dy = sd_decode(op_y[3*i +: 3]);
    assign du = sd_decode(op_u[3*i +: 3]);
    assign dv = sd_decode(op_v[3*i +: 3]);

    assign col_sum[i] = {{2{dx[2]}}, dx} + {{2{dy[2]}}, dy}
                      + {{2{du[2]}}, du} + {{2{dv[2]}}, dv};

    if (i == 0) begin : g_base
      assign below_pos[i] = 1'b0;
    end else begin : g_upper
      assign below_pos[i] = !col_sum[i-1][SUM_W-1] && (col_sum[i-1] != '0);
    end

    sdr4_col_split u_split (
      .col_sum  (col_sum[i]),
      .below_pos(below_pos[i]),
      .carry    (col_carry[i]),
      .part     (col_part[i])
    );

    if (i == 0) begin : g_lsd
      sdr4_digit_merge u_merge (
        .part    (col_part[i]),
        .carry_in(3'sd0),
        .digit   (sum[3*i +: 3])
      );
    end else begin : g_msd
      sdr4_digit_merge u_merge (
        .part    (col_part[i]),
        .carry_in(col_carry[i-1]),
        .digit   (sum[3*i +: 3])
      );
    end
  end

  // Top digit is the carry out of the highest column
  assign sum[3*N +: 3] = sd_encode(col_carry[N-1]);

endmodule

// File: rtl/sdr4_quad_add.sv
module sdr4_quad_add #(
  parameter int N = 4,
  localparam int XW = 3 * N,
  localparam int ZW = 3 * (N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [XW-1:0] in_y,
  input  logic [XW-1:0] in_u,
  input  logic [XW-1:0] in_v,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [ZW-1:0] out_sum
);

  logic [ZW-1:0] core_sum;
  logic [ZW-1:0] sum_q;
  logic          valid_q;

  sdr4_sum_core #(.N(N)) u_core (
    .op_x(in_x),
    .op_y(in_y),
    .op_u(in_u),
    .op_v(in_v),
    .sum (core_sum)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) sum_q <= core_sum;
    end
  end

  assign out_valid = valid_q;
  assign out_sum   = sum_q;

endmodule

// File: rtl/sdr4_quad_add_chk.sv
module sdr4_quad_add_chk #(
  parameter int N = 4,
  localparam int XW = 3 * N,
  localparam int ZW = 3 * (N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [XW-1:0] in_x,
  input logic [XW-1:0] in_y,
  input logic [XW-1:0] in_u,
  input logic [XW-1:0] in_v,
  input logic          out_valid,
  input logic          out_ready,
  input logic [ZW-1:0] out_sum
);

  function automatic longint code_val(input logic [2:0] c);
    longint m;
    m = longint'(c[1:0]);
    return c[2] ? -m : m;
  endfunction

  function automatic longint opnd_val(input logic [XW-1:0] d);
    longint acc, w;
    acc = 0;
    w = 1;
    for (int i = 0; i < N; i++) begin
      acc += code_val(d[3*i +: 3]) * w;
      w *= 4;
    end
    return acc;
  endfunction

  function automatic longint res_val(input logic [ZW-1:0] d);
    longint acc, w;
    acc = 0;
    w = 1;
    for (int i = 0; i <= N; i++) begin
      acc += code_val(d[3*i +: 3]) * w;
      w *= 4;
    end
    return acc;
  endfunction

  function automatic logic has_neg_zero(input logic [ZW-1:0] d);
    logic found;
    found = 1'b0;
    for (int i = 0; i <= N; i++) begin
      if (d[3*i +: 3] == 3'b100) found = 1'b1;
    end
    return found;
  endfunction

  longint in_total, out_total;
  always_comb begin
    in_total  = opnd_val(in_x) + opnd_val(in_y) + opnd_val(in_u) + opnd_val(in_v);
    out_total = res_val(out_sum);
  end

  // R2: the registered sum carries the value of the accepted operands
  p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_total == $past(in_total)))
    else $error("p_value_r2 violated");

  // R3: no output digit uses the negative-zero code
  p_digit_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !has_neg_zero(out_sum))
    else $error("p_digit_code_r3 violated");

  // R7: an accepted operand set yields a valid result after the edge
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("p_accept_r7 violated");

  // R8: a stalled result holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)))
    else $error("p_stall_hold_r8 violated");

endmodule

bind sdr4_quad_add sdr4_quad_add_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_x     (in_x),
  .in_y     (in_y),
  .in_u     (in_u),
  .in_v     (in_v),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sum  (out_sum)
);

// File: tb/tb_sdr4_quad_add.sv
module tb_sdr4_quad_add;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int XW = 3 * N;
  localparam int ZW = 3 * (N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [XW-1:0] in_x, in_y, in_u, in_v;
  logic          out_valid;
  logic          out_ready;
  logic [ZW-1:0] out_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic fire_in, fire_out;

  logic [ZW-1:0] exp_q[$];
  int            val_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr4_quad_add #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
  );

  function automatic int dv(input logic [2:0] c);
    int m;
    m = int'(c[1:0]);
    if (c[2]) return -m;
    return m;
  endfunction

  function automatic logic [2:0] enc(input int v);
    if (v < 0) return {1'b1, 2'(-v)};
    return {1'b0, 2'(v)};
  endfunction

  function automatic int opnd(input logic [XW-1:0] d);
    int acc, w;
    acc = 0; w = 1;
    for (int i = 0; i < N; i++) begin acc += dv(d[3*i +: 3]) * w; w *= 4; end
    return acc;
  endfunction

  function automatic int resv(input logic [ZW-1:0] d);
    int acc, w;
    acc = 0; w = 1;
    for (int i = 0; i <= N; i++) begin acc += dv(d[3*i +: 3]) * w; w *= 4; end
    return acc;
  endfunction

  // Reference: search the unique remainder in the band the lower column dictates
  function automatic logic [ZW-1:0] ref_add(input logic [XW-1:0] x, y, u, v);
    int ds[N];
    int cc[N];
    int ss[N];
    logic [ZW-1:0] r;
    for (int i = 0; i < N; i++)
      ds[i] = dv(x[3*i +: 3]) + dv(y[3*i +: 3]) + dv(u[3*i +: 3]) + dv(v[3*i +: 3]);
    for (int i = 0; i < N; i++) begin
      int below;
      below = (i == 0) ? 0 : ds[i-1];
      cc[i] = 0; ss[i] = 0;
      for (int c = -3; c <= 3; c++) begin
        int s;
        s = ds[i] - 4 * c;
        if ((below > 0) ? (s >= -3 && s <= 0) : (s >= 0 && s <= 3)) begin
          cc[i] = c; ss[i] = s;
        end
      end
    end
    for (int i = 0; i < N; i++)
      r[3*i +: 3] = enc(ss[i] + ((i == 0) ? 0 : cc[i-1]));
    r[3*N +: 3] = enc(cc[N-1]);
    return r;
  endfunction

  function automatic logic neg_zero(input logic [ZW-1:0] d);
    logic f;
    f = 1'b0;
    for (int i = 0; i <= N; i++) if (d[3*i +: 3] == 3'b100) f = 1'b1;
    return f;
  endfunction

  task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    expect_eq("R7 out_valid", 64'(out_valid), 64'(exp_q.size() != 0));
    if (out_valid && exp_q.size() != 0) begin
      expect_eq("R4 digits", 64'(out_sum), 64'(exp_q[0]));
      expect_eq("R2 value", 64'(resv(out_sum)), 64'(val_q[0]));
      expect_eq("R3 code", 64'(neg_zero(out_sum)), 64'd0);
    end
  endtask

  // Inputs already driven after a falling edge; resolve handshakes, then wait one cycle
  task automatic tick();
    logic [ZW-1:0] d0;
    int d1;
    #1;
    fire_in  = in_valid && in_ready;
    fire_out = out_valid && out_ready;
    expect_eq("R7 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
    if (fire_out && exp_q.size() != 0) begin
      d0 = exp_q.pop_front();
      d1 = val_q.pop_front();
    end
    if (fire_in) begin
      exp_q.push_back(ref_add(in_x, in_y, in_u, in_v));
      val_q.push_back(opnd(in_x) + opnd(in_y) + opnd(in_u) + opnd(in_v));
    end
    @(negedge clk);
    check_outputs();
  endtask

  task automatic send(input logic [XW-1:0] x, y, u, v);
    in_valid = 1'b1; in_x = x; in_y = y; in_u = u; in_v = v;
    out_ready = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ZW-1:0] cap_a, cap_b;
    logic [XW-1:0] ax, ay, au, av;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_x = '0; in_y = '0; in_u = '0; in_v = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    expect_eq("R9 out_valid", 64'(out_valid), 64'd0);
    expect_eq("R9 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();

    // R6: worked example (N = 4)
    send({3'b011, 3'b110, 3'b101, 3'b001},
         {3'b000, 3'b111, 3'b000, 3'b010},
         {3'b001, 3'b010, 3'b101, 3'b000},
         {3'b001, 3'b000, 3'b111, 3'b000});
    expect_eq("R6 example", 64'(out_sum), 64'({3'b001, 3'b000, 3'b000, 3'b101, 3'b011}));

    // R4: extremes, every column +12 and every column -12
    send({N{3'b011}}, {N{3'b011}}, {N{3'b011}}, {N{3'b011}});
    expect_eq("R4 all max", 64'(resv(out_sum)), 64'(4 * opnd({N{3'b011}})));
    send({N{3'b111}}, {N{3'b111}}, {N{3'b111}}, {N{3'b111}});
    expect_eq("R4 all min", 64'(resv(out_sum)), 64'(4 * opnd({N{3'b111}})));

    // R1: negative-zero input code behaves as zero
    send({N{3'b100}}, {N{3'b001}}, {N{3'b100}}, '0);
    cap_a = out_sum;
    send('0, {N{3'b001}}, '0, '0);
    cap_b = out_sum;
    expect_eq("R1 neg zero", 64'(cap_a), 64'(cap_b));

    // R5: changing only the top column leaves low digits alone
    ax = {3'b011, 3'b110, 3'b010, 3'b111}; ay = {3'b001, 3'b011, 3'b101, 3'b011};
    au = {3'b110, 3'b001, 3'b011, 3'b010}; av = {3'b000, 3'b111, 3'b001, 3'b011};
    send(ax, ay, au, av);
    cap_a = out_sum;
    send({3'b111, ax[XW-4:0]}, ay, au, av);
    cap_b = out_sum;
    expect_eq("R5 locality", 64'(cap_a[3*(N-1)-1:0]), 64'(cap_b[3*(N-1)-1:0]));

    // R8: hold under stall
    in_valid = 1'b1; in_x = ax; in_y = ay; in_u = au; in_v = av; out_ready = 1'b0;
    tick();
    in_valid = 1'b0;
    cap_a = out_sum;
    tick();
    expect_eq("R8 hold", 64'(out_sum), 64'(cap_a));
    expect_eq("R8 valid", 64'(out_valid), 64'd1);

    // Random stream with back-pressure (R2, R3, R4, R7, R8)
    for (int k = 0; k < 600; k++) begin
      out_ready = ($urandom % 4) != 0;
      if (!(in_valid && !fire_in)) begin
        in_valid = ($urandom % 3) != 0;
        in_x = XW'($urandom); in_y = XW'($urandom);
        in_u = XW'($urandom); in_v = XW'($urandom);
      end
      tick();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule